// File: doc/BRIEF.md
# Arithmetic Left Shift Execution Unit

This unit executes the arithmetic left-shift instruction family for a small processor with eight 32-bit general registers. An instruction arrives as a 16-bit opcode on a valid/ready interface. The unit decodes it, extracts a byte, word or long operand from the selected register, and shifts that operand left by one or two places. It writes the result back into only the operand's own bits and updates the condition-code byte.

An opcode transfers on a rising edge where `op_valid` and `op_ready` are both high. The sender must hold `op_code` and `op_valid` steady until that edge. `op_ready` is high except during a cycle in which the test port writes a register or the flags. A decodable instruction completes on the accepting edge and pulses `done` for the following cycle. An undecodable one pulses `illegal` for that cycle and changes nothing.

The test port presets and reads registers and presets the flag byte. The register read through it is combinational.

Top module: `shal_unit`

## Requirements
- R1: An opcode is legal only when bits 15:8 equal 0x10, bit 7 is 1 and bits 5:4 are not 10. Bit 6 set selects a shift by two and clear selects a shift by one. Bits 5:4 select the size: 00 byte, 01 word, 11 long.
- R2: For a byte operation, register field values 8..15 address bits 7:0 of register (field-8), and values 0..7 address bits 15:8 of register (field).
- R3: For a word operation, register field values 0..7 address bits 15:0 of register field[2:0], and values 8..15 address bits 31:16.
- R4: For a long operation, the whole 32-bit register selected by field bits 2:0 is shifted; field bit 3 is ignored.
- R5: C (flag bit 0) takes the last bit shifted out of the sized operand's most significant position.
- R6: N (bit 3) is the sized result's top bit, Z (bit 2) is set only when the sized result is zero, H (bit 5) is cleared, and flag bits 7, 6 and 4 keep their values.
- R7: V (bit 1) is set when any bit that passed through the sign position differs from the final sign bit; otherwise it is cleared.
- R8: Bits of the destination register outside the addressed slice, and all other registers, keep their values.
- R9: An illegal opcode leaves registers and flags unchanged, raises `illegal` for exactly one cycle and does not raise `done`.
- R10: `done` is high for exactly the one cycle after a legal opcode is accepted, and the written register and flags are visible in that cycle. With no acceptance, neither `done` nor `illegal` rises.
- R11: `op_ready` is low in any cycle where `tp_we` or `tp_flags_we` is high, and an opcode presented then has no effect.
- R12: After reset, all registers and flags read zero and `done` and `illegal` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Opcode valid |
| op_ready | output | 1 | Unit can accept an opcode |
| op_code | input | 16 | Instruction opcode |
| done | output | 1 | Legal instruction completed last edge |
| illegal | output | 1 | Illegal opcode accepted last edge |
| flags | output | 8 | Condition-code byte |
| tp_we | input | 1 | Test port register write |
| tp_idx | input | 3 | Test port register index (read and write) |
| tp_wdata | input | 32 | Test port register write data |
| tp_rdata | output | 32 | Test port register read data |
| tp_flags_we | input | 1 | Test port flag write |
| tp_flags_wdata | input | 8 | Test port flag write data |

## Verification
Every architectural result of an accepted opcode is due one cycle after the accepting edge: the `done` or `illegal` pulse, the new register contents and the new flags. The bench drives opcodes on a falling edge and checks all of these on the next falling edge, after exactly one rising edge. It then checks on the following falling edge that the pulse has gone. Register contents are read through the combinational test port in that same sampling window, so no extra latency enters the count.

// File: rtl/shal_pkg.sv
package shal_pkg;
  localparam int GPR_COUNT  = 8;
  localparam int GPR_WIDTH  = 32;
  localparam int OPC_WIDTH  = 16;
  localparam logic [7:0] OPC_PREFIX = 8'h10;

  localparam int FL_C = 0;
  localparam int FL_V = 1;
  localparam int FL_Z = 2;
  localparam int FL_N = 3;
  localparam int FL_H = 5;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_RSVD = 2'b10,
    SZ_LONG = 2'b11
  } size_e;

  typedef struct packed {
    logic       legal;
    logic       by_two;
    size_e      size;
    logic       upper;    // register field bit 3
    logic [2:0] gpr;
  } dec_t;
endpackage

// File: rtl/shal_decode.sv
module shal_decode
  import shal_pkg::*;
#(
  parameter int OPC_W = OPC_WIDTH
) (
  input  logic [OPC_W-1:0] opcode,
  output dec_t             dec
);
  logic [7:0] hi_b;
  logic [7:0] lo_b;

  assign hi_b = opcode[OPC_W-1 -: 8];
  assign lo_b = opcode[7:0];

  always_comb begin
    dec.by_two = lo_b[6];
    dec.size   = size_e'(lo_b[5:4]);
    dec.upper  = lo_b[3];
    dec.gpr    = lo_b[2:0];
    dec.legal  = (hi_b == OPC_PREFIX) && lo_b[7] && (lo_b[5:4] != SZ_RSVD);
  end
endmodule

// File: rtl/shal_shifter.sv
module shal_shifter
  import shal_pkg::*;
#(
  parameter int XW = GPR_WIDTH
) (
  input  logic [XW-1:0] operand,
  input  size_e         size,
  input  logic          by_two,
  output logic [XW-1:0] result,
  output logic          n_o,
  output logic          z_o,
  output logic          v_o,
  output logic          c_o
);
  localparam int LANES = 3;

  logic [XW-1:0] lane_res [LANES];
  logic [LANES-1:0] lane_n, lane_z, lane_v, lane_c;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int W = 8 << g;
    logic [W-1:0] x;
    logic [W-1:0] r;
    assign x = operand[W-1:0];
    assign r = by_two ? (x << 2) : (x << 1);
    assign lane_res[g] = XW'(r);
    assign lane_n[g]   = r[W-1];
    assign lane_z[g]   = (r == '0);
    assign lane_c[g]   = by_two ? x[W-2] : x[W-1];
    assign lane_v[g]   = by_two ? ((x[W-1] ^ x[W-3]) | (x[W-2] ^ x[W-3]))
                                : (x[W-1] ^ x[W-2]);
  end

  logic [1:0] sel;
  always_comb begin
    unique case (size)
      SZ_BYTE: sel = 2'd0;
      SZ_WORD: sel = 2'd1;
      default: sel = 2'd2;
    endcase
    result = lane_res[sel];
    n_o    = lane_n[sel];
    z_o    = lane_z[sel];
    v_o    = lane_v[sel];
    c_o    = lane_c[sel];
  end
endmodule

// File: rtl/shal_gpr_file.sv
module shal_gpr_file
  import shal_pkg::*;
#(
  parameter int NREG = GPR_COUNT,
  parameter int XW   = GPR_WIDTH,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [XW-1:0] wr_data,
  input  logic [AW-1:0] ra_idx,
  output logic [XW-1:0] ra_data,
  input  logic [AW-1:0] rb_idx,
  output logic [XW-1:0] rb_data
);
  logic [XW-1:0] q [NREG];
  logic [NREG-1:0] wsel;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    assign wsel[i] = wr_en && (wr_idx == AW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q[i] <= '0;
      else if (wsel[i]) q[i] <= wr_data;
    end
  end

  assign ra_data = q[ra_idx];
  assign rb_data = q[rb_idx];

  // R8: at most one register is written per edge
  a_r8_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wsel));
endmodule

// File: rtl/shal_unit.sv
module shal_unit
  import shal_pkg::*;
#(
  parameter int NREG  = GPR_COUNT,
  parameter int XW    = GPR_WIDTH,
  parameter int OPC_W = OPC_WIDTH,
  localparam int AW   = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  output logic             op_ready,
  input  logic [OPC_W-1:0] op_code,
  output logic             done,
  output logic             illegal,
  output logic [7:0]       flags,
  input  logic             tp_we,
  input  logic [AW-1:0]    tp_idx,
  input  logic [XW-1:0]    tp_wdata,
  output logic [XW-1:0]    tp_rdata,
  input  logic             tp_flags_we,
  input  logic [7:0]       tp_flags_wdata
);
  dec_t dec;
  logic accept;
  logic [XW-1:0] src, operand, shifted, merged, wr_data;
  logic n_f, z_f, v_f, c_f;
  logic [7:0] flags_q;
  logic done_q, illegal_q;
  logic wr_en;
  logic [AW-1:0] wr_idx;

  assign op_ready = !(tp_we || tp_flags_we);
  assign accept   = op_valid && op_ready;

  shal_decode #(.OPC_W(OPC_W)) u_decode (
    .opcode (op_code),
    .dec    (dec)
  );

  // operand extraction
  always_comb begin
    unique case (dec.size)
      SZ_BYTE: operand = XW'(dec.upper ? src[7:0] : src[15:8]);
      SZ_WORD: operand = XW'(dec.upper ? src[31:16] : src[15:0]);
      default: operand = src;
    endcase
  end

  shal_shifter #(.XW(XW)) u_shift (
    .operand (operand),
    .size    (dec.size),
    .by_two  (dec.by_two),
    .result  (shifted),
    .n_o     (n_f),
    .z_o     (z_f),
    .v_o     (v_f),
    .c_o     (c_f)
  );

  // slice merge back into the destination register
  always_comb begin
    unique case (dec.size)
      SZ_BYTE: merged = dec.upper ? {src[31:8], shifted[7:0]}
                                  : {src[31:16], shifted[7:0], src[7:0]};
      SZ_WORD: merged = dec.upper ? {shifted[15:0], src[15:0]}
                                  : {src[31:16], shifted[15:0]};
      default: merged = shifted;
    endcase
  end

  assign wr_en   = tp_we || (accept && dec.legal);
  assign wr_idx  = tp_we ? tp_idx : AW'(dec.gpr);
  assign wr_data = tp_we ? tp_wdata : merged;

  shal_gpr_file #(.NREG(NREG), .XW(XW)) u_gpr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .ra_idx  (AW'(dec.gpr)),
    .ra_data (src),
    .rb_idx  (tp_idx),
    .rb_data (tp_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q   <= '0;
      done_q    <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      done_q    <= accept && dec.legal;
      illegal_q <= accept && !dec.legal;
      if (tp_flags_we) begin
        flags_q <= tp_flags_wdata;
      end else if (accept && dec.legal) begin
        flags_q[FL_H] <= 1'b0;
        flags_q[FL_N] <= n_f;
        flags_q[FL_Z] <= z_f;
        flags_q[FL_V] <= v_f;
        flags_q[FL_C] <= c_f;
      end
    end
  end

  assign flags   = flags_q;
  assign done    = done_q;
  assign illegal = illegal_q;

  // R11: no opcode taken while the test port writes
  a_r11_blocked_by_test: assert property (@(posedge clk) disable iff (!rst_n)
    (tp_we || tp_flags_we) |-> !op_ready);
  // R10: a legal acceptance yields done next cycle
  a_r10_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dec.legal) |=> done);
  // R10: no acceptance, no pulse
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> (!done && !illegal));
  // R9: illegal never coincides with done and leaves flags alone
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && illegal));
  a_r9_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> $stable(flags_q));
  // R6: half-carry is clear after any completed shift
  a_r6_h_clear: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !flags_q[FL_H]);
endmodule

// File: tb/shal_unit_tb.sv
module shal_unit_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, op_valid, op_ready, done, illegal, tp_we, tp_flags_we;
  logic [15:0] op_code;
  logic [7:0] flags, tp_flags_wdata;
  logic [2:0] tp_idx;
  logic [31:0] tp_wdata, tp_rdata;

  shal_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .done(done), .illegal(illegal), .flags(flags),
    .tp_we(tp_we), .tp_idx(tp_idx), .tp_wdata(tp_wdata), .tp_rdata(tp_rdata),
    .tp_flags_we(tp_flags_we), .tp_flags_wdata(tp_flags_wdata)
  );

  int checks = 0, failures = 0;
  bit finished = 0;

  localparam int NV = 16;
  localparam logic [15:0] V_OP  [NV] = '{16'h1088, 16'h10C8, 16'h1090, 16'h10D0,
    16'h10B0, 16'h10F0, 16'h108B, 16'h1083, 16'h109D, 16'h10B7, 16'h1088,
    16'h10B0, 16'h10D0, 16'h10C8, 16'h10F0, 16'h10BE};
  localparam logic [2:0]  V_IDX [NV] = '{3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0,
    3'd3, 3'd3, 3'd5, 3'd7, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd6};
  localparam logic [31:0] V_PRE [NV] = '{32'hA5A5A5A5, 32'hA5A5A5A5,
    32'hA5A5A5A5, 32'hA5A5A5A5, 32'hA5A5A5A5, 32'hA5A5A5A5, 32'hA5A5A5A5,
    32'hA5A5A5A5, 32'hA5A5A5A5, 32'hA5A5A5A5, 32'h00000080, 32'h40000000,
    32'h0000C000, 32'h000000E0, 32'hC0000001, 32'hA5A5A5A5};
  localparam logic [31:0] V_EXP [NV] = '{32'hA5A5A54A, 32'hA5A5A594,
    32'hA5A54B4A, 32'hA5A59694, 32'h4B4B4B4A, 32'h96969694, 32'hA5A5A54A,
    32'hA5A54AA5, 32'h4B4AA5A5, 32'h4B4B4B4A, 32'h00000000, 32'h80000000,
    32'h00000000, 32'h00000080, 32'h00000004, 32'h4B4B4B4A};
  // N Z V C
  localparam logic [3:0]  V_NZVC [NV] = '{4'h3, 4'hA, 4'h3, 4'hA, 4'h3, 4'hA,
    4'h3, 4'h3, 4'h3, 4'h3, 4'h7, 4'hA, 4'h7, 4'h9, 4'h3, 4'h3};

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic set_reg(int i, logic [31:0] v);
    @(negedge clk);
    tp_we = 1'b1; tp_idx = 3'(i); tp_wdata = v;
    @(negedge clk);
    tp_we = 1'b0;
  endtask

  task automatic set_flags(logic [7:0] v);
    @(negedge clk);
    tp_flags_we = 1'b1; tp_flags_wdata = v;
    @(negedge clk);
    tp_flags_we = 1'b0;
  endtask

  task automatic get_reg(int i, output logic [31:0] v);
    tp_idx = 3'(i);
    #1;
    v = tp_rdata;
  endtask

  task automatic issue(logic [15:0] op);
    @(negedge clk);
    op_valid = 1'b1; op_code = op;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic fill_all(logic [31:0] v);
    for (int r = 0; r < 8; r++) set_reg(r, v);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    rst_n = 1'b0; op_valid = 1'b0; op_code = '0; tp_we = 1'b0; tp_idx = '0;
    tp_wdata = '0; tp_flags_we = 1'b0; tp_flags_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    chk("R12 done", 32'(done), 32'd0);
    chk("R12 illegal", 32'(illegal), 32'd0);
    chk("R12 flags", 32'(flags), 32'd0);
    chk("R11 ready idle", 32'(op_ready), 32'd1);
    for (int r = 0; r < 8; r++) begin
      get_reg(r, rv);
      chk("R12 register zero", rv, 32'd0);
    end

    // table of vectors
    for (int k = 0; k < NV; k++) begin
      fill_all(32'hA5A5A5A5);
      set_reg(V_IDX[k], V_PRE[k]);
      set_flags(8'hF0);
      issue(V_OP[k]);
      chk("R10 done pulse", 32'(done), 32'd1);
      chk("R1 legal opcode", 32'(illegal), 32'd0);
      chk("R6 R5 R7 flags", 32'(flags), 32'({4'hD, V_NZVC[k]}));
      get_reg(V_IDX[k], rv);
      chk("R2 R3 R4 result", rv, V_EXP[k]);
      for (int r = 0; r < 8; r++) begin
        if (r != int'(V_IDX[k])) begin
          get_reg(r, rv);
          chk("R8 other register", rv, 32'hA5A5A5A5);
        end
      end
      @(negedge clk);
      chk("R10 done single cycle", 32'(done), 32'd0);
    end

    // R9 illegal opcodes
    fill_all(32'hA5A5A5A5);
    set_flags(8'h2C);
    issue(16'h1188);
    chk("R9 illegal wrong prefix", 32'(illegal), 32'd1);
    chk("R9 no done", 32'(done), 32'd0);
    chk("R9 flags kept", 32'(flags), 32'h2C);
    get_reg(0, rv);
    chk("R9 register kept", rv, 32'hA5A5A5A5);
    @(negedge clk);
    chk("R9 illegal single cycle", 32'(illegal), 32'd0);
    issue(16'h10A0);
    chk("R1 R9 reserved size", 32'(illegal), 32'd1);
    chk("R9 flags kept size", 32'(flags), 32'h2C);
    get_reg(0, rv);
    chk("R9 register kept size", rv, 32'hA5A5A5A5);
    issue(16'h1008);
    chk("R1 R9 bit7 clear", 32'(illegal), 32'd1);
    get_reg(0, rv);
    chk("R9 register kept bit7", rv, 32'hA5A5A5A5);

    // R11 back-pressure from the test port
    @(negedge clk);
    tp_we = 1'b1; tp_idx = 3'd2; tp_wdata = 32'h12345678;
    op_valid = 1'b1; op_code = 16'h1088;
    #1;
    chk("R11 ready low", 32'(op_ready), 32'd0);
    @(negedge clk);
    tp_we = 1'b0; op_valid = 1'b0;
    chk("R11 no done", 32'(done), 32'd0);
    chk("R11 flags untouched", 32'(flags), 32'h2C);
    get_reg(0, rv);
    chk("R11 opcode ignored", rv, 32'hA5A5A5A5);
    get_reg(2, rv);
    chk("R11 test write", rv, 32'h12345678);

    finished = 1;
    summary();
    $finish;
  end
endmodule